// File: doc/BRIEF.md
# Channel Enable and Suspend Control Register

This block holds the shared run/pause control word of a multi-channel DMA engine with up to eight channels. A single 32-bit write word carries, for every channel, a run bit and a pause bit, each guarded by its own write-enable bit in the same word. A write changes a channel's run or pause bit only when that bit's write-enable is set. Software can therefore start, stop, pause or resume one channel without first reading the word, and it cannot undo a change that hardware made in the meantime.

The block drives a run level and a pause request level to each channel. Each channel sends back three signals: a completion pulse, an error pulse and an idle-between-bursts level. A completion or error pulse drops that channel's run bit on the next clock. When a channel that has a pending pause request first reports idle, the block emits a one-cycle paused event. Software reads the word back to learn which channels are still busy. A channel whose run bit is still set must not be restarted.

Top module: `chan_en_reg`

## Requirements
- R1: After reset every run bit and pause bit is 0, so the read word, `chanActive`, `chanSuspReq` and `suspEvt` are all zero.
- R2: Run bits sit at bits [7:0] and their write-enables at [15:8], with bit index equal to channel index. A write with a write-enable at 1 copies the data bit into that channel's run bit, visible one clock later.
- R3: In a write, a channel whose write-enable bit is 0 keeps both its run bit and its pause bit, whatever its data bits hold.
- R4: The write-enable fields [15:8] and [31:24] always read back as zero. The read word shows run bits at [7:0] and pause bits at [23:16].
- R5: Pause bits sit at [23:16] and their write-enables at [31:24]. They are set and cleared the same way as run bits and independently of them.
- R6: A completion or error pulse on a channel clears its run bit on the next clock and leaves its pause bit alone.
- R7: If a completion or error pulse and a software write that sets the same channel's run bit arrive in the same cycle, the run bit ends up 0.
- R8: `suspEvt` for a channel is high in the first cycle in which its pause bit is set and `chanIdle` is high, and it stays low after that until the pause bit has been cleared and set again. A channel that is idle with no pause bit set raises no event.
- R9: Clearing a pause bit, with its write-enable at 1, drops `chanSuspReq` for that channel on the next clock and leaves its run bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word with run, run-WE, pause and pause-WE fields |
| doneEvt | input | NUM_CH | Per-channel transfer-complete pulse |
| errEvt | input | NUM_CH | Per-channel error pulse |
| chanIdle | input | NUM_CH | Per-channel idle-between-bursts level |
| rdData | output | 32 | Read-back word: run bits and pause bits, write-enable fields zero |
| chanActive | output | NUM_CH | Run level to each channel |
| chanSuspReq | output | NUM_CH | Pause request level to each channel |
| suspEvt | output | NUM_CH | One-cycle paused event per channel |

## Verification
The main function is tried with writes whose data and write-enable fields disagree. These include all data bits at one with only a few enables set, enables set with data at zero, and a pause-only write next to a run-only write, which shows that the write-enable, and not the data, decides what changes. Hardware clears are applied alone and together with a software set of the same channel, which separates the clear path from its priority. The paused event is driven with idle held across several cycles, with the pause bit toggled, and with idle on a channel that has no pause request, so that a single pulse, a re-arm and a false trigger can each be told apart.

// File: rtl/chan_en_pkg.sv
package chan_en_pkg;
  localparam int REG_W      = 32;
  localparam int FIELD_W    = 8;
  localparam int EN_POS     = 0;
  localparam int EN_WE_POS  = 8;
  localparam int SUS_POS    = 16;
  localparam int SUS_WE_POS = 24;

  typedef struct packed {
    logic [FIELD_W-1:0] setEn;
    logic [FIELD_W-1:0] clrEn;
    logic [FIELD_W-1:0] setSus;
    logic [FIELD_W-1:0] clrSus;
  } chenStrobes_t;
endpackage

// File: rtl/chan_en_ctrl.sv
module chan_en_ctrl
  import chan_en_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              wrValid,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  output chenStrobes_t      strobes
);
  logic [NUM_CH-1:0] enVal, enWe, susVal, susWe, hwClr;

  assign enVal  = wrData[EN_POS     +: NUM_CH];
  assign enWe   = wrData[EN_WE_POS  +: NUM_CH];
  assign susVal = wrData[SUS_POS    +: NUM_CH];
  assign susWe  = wrData[SUS_WE_POS +: NUM_CH];
  assign hwClr  = doneEvt | errEvt;

  for (genvar ch = 0; ch < FIELD_W; ch++) begin : g_ch
    if (ch < NUM_CH) begin : g_live
      logic enHit, susHit;
      assign enHit  = wrValid & enWe[ch];
      assign susHit = wrValid & susWe[ch];
      // hardware clear outranks a software set in the same cycle
      assign strobes.setEn[ch]  = enHit & enVal[ch] & ~hwClr[ch];
      assign strobes.clrEn[ch]  = (enHit & ~enVal[ch]) | hwClr[ch];
      assign strobes.setSus[ch] = susHit & susVal[ch];
      assign strobes.clrSus[ch] = susHit & ~susVal[ch];
    end else begin : g_tie
      assign strobes.setEn[ch]  = 1'b0;
      assign strobes.clrEn[ch]  = 1'b0;
      assign strobes.setSus[ch] = 1'b0;
      assign strobes.clrSus[ch] = 1'b0;
    end
  end
endmodule

// File: rtl/chan_en_dp.sv
module chan_en_dp
  import chan_en_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chenStrobes_t      strobes,
  input  logic [NUM_CH-1:0] chanIdle,
  output logic [NUM_CH-1:0] enBits,
  output logic [NUM_CH-1:0] susBits,
  output logic [NUM_CH-1:0] suspPulse,
  output logic [REG_W-1:0]  rdWord
);
  logic [NUM_CH-1:0] reported;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBits   <= '0;
      susBits  <= '0;
      reported <= '0;
    end else begin
      enBits   <= (enBits  | strobes.setEn[NUM_CH-1:0])  & ~strobes.clrEn[NUM_CH-1:0];
      susBits  <= (susBits | strobes.setSus[NUM_CH-1:0]) & ~strobes.clrSus[NUM_CH-1:0];
      reported <= susBits & (reported | suspPulse);
    end
  end

  assign suspPulse = susBits & chanIdle & ~reported;

  always_comb begin
    rdWord = '0;
    rdWord[EN_POS  +: NUM_CH] = enBits;
    rdWord[SUS_POS +: NUM_CH] = susBits;
  end
endmodule

// File: rtl/chan_en_reg.sv
module chan_en_reg
  import chan_en_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] chanIdle,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] chanActive,
  output logic [NUM_CH-1:0] chanSuspReq,
  output logic [NUM_CH-1:0] suspEvt
);
  chenStrobes_t strobes;

  chan_en_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .wrValid(wrValid), .wrData(wrData), .doneEvt(doneEvt),
    .errEvt(errEvt), .strobes(strobes)
  );

  chan_en_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chanIdle(chanIdle),
    .enBits(chanActive), .susBits(chanSuspReq), .suspPulse(suspEvt),
    .rdWord(rdData)
  );
endmodule

// File: rtl/chan_en_reg_chk.sv
module chan_en_reg_chk
  import chan_en_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [REG_W-1:0]  wrData,
  input logic [NUM_CH-1:0] doneEvt,
  input logic [NUM_CH-1:0] errEvt,
  input logic [NUM_CH-1:0] chanIdle,
  input logic [REG_W-1:0]  rdData,
  input logic [NUM_CH-1:0] chanActive,
  input logic [NUM_CH-1:0] chanSuspReq,
  input logic [NUM_CH-1:0] suspEvt
);
  logic [NUM_CH-1:0] hw, enWeMask, susWeMask, setMask;
  assign hw        = doneEvt | errEvt;
  assign enWeMask  = wrValid ? wrData[EN_WE_POS  +: NUM_CH] : '0;
  assign susWeMask = wrValid ? wrData[SUS_WE_POS +: NUM_CH] : '0;
  assign setMask   = enWeMask & wrData[EN_POS +: NUM_CH] & ~hw;

  assert_hw_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive & $past(hw)) == '0);

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (~chanActive & $past(setMask)) == '0);

  assert_untouched_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((chanActive ^ $past(chanActive)) & ~$past(enWeMask) & ~$past(hw)) == '0
    && ((chanSuspReq ^ $past(chanSuspReq)) & ~$past(susWeMask)) == '0);

  assert_we_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[EN_WE_POS +: FIELD_W] == '0 && rdData[SUS_WE_POS +: FIELD_W] == '0);

  assert_susp_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (suspEvt & $past(suspEvt)) == '0);

  assert_susp_needs_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (suspEvt & ~(chanIdle & chanSuspReq)) == '0);
endmodule

bind chan_en_reg chan_en_reg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
  .doneEvt(doneEvt), .errEvt(errEvt), .chanIdle(chanIdle),
  .rdData(rdData), .chanActive(chanActive), .chanSuspReq(chanSuspReq),
  .suspEvt(suspEvt)
);

// File: tb/tb_chan_en_reg.sv
module tb_chan_en_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  typedef struct packed {
    logic        wv;
    logic [31:0] wd;
    logic [7:0]  dn;
    logic [7:0]  er;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    {1'b1, 32'h0000FF0F, 8'h00, 8'h00, 32'h0000000F},  // R2 set low four
    {1'b1, 32'h000030FF, 8'h00, 8'h00, 32'h0000003F},  // R3 only ch4,5 move
    {1'b1, 32'h00000300, 8'h00, 8'h00, 32'h0000003C},  // R2 clear ch0,1
    {1'b1, 32'h0CFF0000, 8'h00, 8'h00, 32'h000C003C},  // R5 pause ch2,3
    {1'b0, 32'h00000000, 8'h04, 8'h00, 32'h000C0038},  // R6 done ch2
    {1'b1, 32'h00002121, 8'h00, 8'h20, 32'h000C0019},  // R7 err ch5 beats set
    {1'b1, 32'h04000000, 8'h00, 8'h00, 32'h00080019},  // R9 resume ch2
    {1'b1, 32'h00FF00FF, 8'h00, 8'h00, 32'h00080019}   // R3 R4 no enables
  };

  logic clk = 1'b0, rstN = 1'b0, wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [NCH-1:0] doneEvt = '0, errEvt = '0, chanIdle = '0;
  logic [31:0] rdData;
  logic [NCH-1:0] chanActive, chanSuspReq, suspEvt;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_en_reg #(.NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .doneEvt(doneEvt), .errEvt(errEvt), .chanIdle(chanIdle),
    .rdData(rdData), .chanActive(chanActive), .chanSuspReq(chanSuspReq),
    .suspEvt(suspEvt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(logic wv, logic [31:0] wd, logic [7:0] dn, logic [7:0] er);
    wrValid = wv; wrData = wd; doneEvt = dn; errEvt = er;
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0; wrData = '0; doneEvt = '0; errEvt = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 read", rdData, 32'h0);
    check("R1 outputs", {8'h0, chanActive, chanSuspReq, suspEvt}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i].wv, VECS[i].wd, VECS[i].dn, VECS[i].er);
      check($sformatf("R2 R3 R4 R5 R6 R7 R9 vector %0d read", i), rdData, VECS[i].exp);
      check($sformatf("R2 R5 R9 vector %0d levels", i),
            {16'h0, chanSuspReq, chanActive},
            {16'h0, VECS[i].exp[23:16], VECS[i].exp[7:0]});
    end

    // R8: idle on ch0 without pause, ch3 with pause
    chanIdle = 8'h09;
    #1;
    check("R8 first idle cycle", {24'h0, suspEvt}, 32'h08);
    @(negedge clk);
    check("R8 no repeat", {24'h0, suspEvt}, 32'h00);
    @(negedge clk);
    check("R8 still quiet", {24'h0, suspEvt}, 32'h00);
    // clear pause ch3, then set again with idle held
    cycle(1'b1, 32'h08000000, 8'h00, 8'h00);
    check("R9 resume ch3", {24'h0, chanSuspReq}, 32'h00);
    check("R9 run kept", {24'h0, chanActive}, 32'h19);
    @(negedge clk);
    cycle(1'b1, 32'h08080000, 8'h00, 8'h00);
    check("R8 re-armed", {24'h0, suspEvt}, 32'h08);
    chanIdle = 8'h00;
    // R6 pause bit untouched by error
    cycle(1'b0, 32'h0, 8'h00, 8'h08);
    check("R6 pause kept", rdData, 32'h00080011);
    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again", rdData, 32'h0);
    finish_run();
  end
endmodule